// File: doc/BRIEF.md
# Status Flag Manipulation Unit

This unit owns an eight-bit processor status word and performs the explicit flag instructions of a small integer core. It sets or clears any flag by number, and it also accepts short set and clear forms that carry the flag number inside the operation code. It moves a single register bit into the transfer flag T, and it writes T back into a chosen bit of a register. It also tests a flag for the branch unit and reports the branch decision together with the cycle cost of the branch.

Results are registered. A flag change is visible on `sreg_o` one clock after the operation is presented. The write-back data and its strobe for a bit-load, and the branch verdict, also appear one clock later. An external update port lets the arithmetic logic replace the whole word. When an explicit flag operation arrives in the same cycle, the explicit operation takes precedence.

Top module: `sreg_bitman_unit`

## Requirements
- R1: A synchronous active-high reset clears all status bits to 0 and drives `reg_we_o`, `br_valid_o`, `br_taken_o` and `br_cycles_o` to 0.
- R2: Op code 5'h01 (flag set) forces status bit `flag_idx_i` to 1 one clock later. All other bits are left unchanged.
- R3: Op code 5'h02 (flag clear) forces status bit `flag_idx_i` to 0 one clock later. All other bits are left unchanged.
- R4: Op codes with bit 4 high are short forms. Bit 3 selects set (1) or clear (0), and bits 2:0 name the flag. `flag_idx_i` is ignored for these codes.
- R5: Flag positions from bit 0 to bit 7 are carry, zero, negative, overflow, sign, half-carry, T and global interrupt enable.
- R6: Op code 5'h03 (bit store) copies bit `bit_idx_i` of `reg_data_i` into T (bit 6) and changes no other flag.
- R7: Op code 5'h04 (bit load) returns `reg_data_i` with bit `bit_idx_i` replaced by T on `reg_data_o`. It pulses `reg_we_o` for one cycle, one clock later, and changes no flag.
- R8: Op code 5'h05 (branch if set) and 5'h06 (branch if clear) test status bit `flag_idx_i`. One clock later they raise `br_valid_o` for one cycle, with `br_taken_o` high when the bit equals 1 (or 0 for the clear form).
- R9: With `br_valid_o` high, `br_cycles_o` reads 2 for a taken branch and 1 for a branch not taken.
- R10: When `ext_we_i` is high, `ext_flags_i` replaces the status word one clock later, unless the same cycle carries a flag set, flag clear, short form or bit store. In that case the explicit operation is applied and the external word is dropped.
- R11: Op codes 5'h00 and 5'h07 to 5'h0F change no flag and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| flag_idx_i | input | 3 | Flag number for indexed set/clear and branch tests |
| bit_idx_i | input | 3 | Register bit number for bit store/load |
| reg_data_i | input | 8 | Register operand |
| ext_we_i | input | 1 | External status word update enable |
| ext_flags_i | input | 8 | External status word |
| sreg_o | output | 8 | Current status word |
| reg_data_o | output | 8 | Register data after bit load |
| reg_we_o | output | 1 | Write strobe for `reg_data_o` |
| br_valid_o | output | 1 | Branch verdict valid |
| br_taken_o | output | 1 | Branch taken |
| br_cycles_o | output | 2 | Branch cost in cycles, 0 when not valid |

## Verification
The status word is visible at every port cycle. A bit that is set wrongly or left standing shows up on `sreg_o` on the clock after the faulty operation. Corruption of T shows up indirectly as well, since the next bit load writes the wrong bit value and the next branch on bit 6 gives the wrong verdict. The bench therefore follows each state change with both a direct read of `sreg_o` and later operations that consume that state. It also exercises collisions with the external update port, where a wrong priority leaves a whole word changed a single clock later.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int SREG_W  = 8;
    localparam int FIDX_W  = $clog2(SREG_W);
    localparam int OP_W    = 5;

    localparam logic [OP_W-1:0] OP_NOP   = 5'h00;
    localparam logic [OP_W-1:0] OP_FSET  = 5'h01;
    localparam logic [OP_W-1:0] OP_FCLR  = 5'h02;
    localparam logic [OP_W-1:0] OP_BST   = 5'h03;
    localparam logic [OP_W-1:0] OP_BLD   = 5'h04;
    localparam logic [OP_W-1:0] OP_BRSET = 5'h05;
    localparam logic [OP_W-1:0] OP_BRCLR = 5'h06;

    typedef enum logic [FIDX_W-1:0] {
        FL_C = 3'd0,
        FL_Z = 3'd1,
        FL_N = 3'd2,
        FL_V = 3'd3,
        FL_S = 3'd4,
        FL_H = 3'd5,
        FL_T = 3'd6,
        FL_I = 3'd7
    } flag_e;

    typedef struct packed {
        logic              set_en;
        logic              clr_en;
        logic [FIDX_W-1:0] sel;
        logic              bst_en;
        logic              bld_en;
        logic              br_en;
        logic              br_want;
    } ctrl_t;

    function automatic logic is_short(input logic [OP_W-1:0] op);
        return op[OP_W-1];
    endfunction

    function automatic logic [SREG_W-1:0] onehot(input logic [FIDX_W-1:0] idx);
        logic [SREG_W-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
    import sreg_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [FIDX_W-1:0] flag_idx_i,
    output ctrl_t             ctrl_o
);
    always_comb begin
        ctrl_o = '0;
        ctrl_o.sel = flag_idx_i;
        if (is_short(op_i)) begin
            ctrl_o.sel    = op_i[FIDX_W-1:0];
            ctrl_o.set_en = op_i[FIDX_W];
            ctrl_o.clr_en = ~op_i[FIDX_W];
        end else begin
            unique case (op_i)
                OP_FSET:  ctrl_o.set_en = 1'b1;
                OP_FCLR:  ctrl_o.clr_en = 1'b1;
                OP_BST:   ctrl_o.bst_en = 1'b1;
                OP_BLD:   ctrl_o.bld_en = 1'b1;
                OP_BRSET: begin
                    ctrl_o.br_en   = 1'b1;
                    ctrl_o.br_want = 1'b1;
                end
                OP_BRCLR: begin
                    ctrl_o.br_en   = 1'b1;
                    ctrl_o.br_want = 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sreg_file.sv
module sreg_file
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl_i,
    input  logic              t_new_i,
    input  logic              ext_we_i,
    input  logic [SREG_W-1:0] ext_flags_i,
    output logic [SREG_W-1:0] sreg_o
);
    logic [SREG_W-1:0] sreg_q, sreg_d, mask;
    logic              explicit;

    assign mask     = onehot(ctrl_i.sel);
    assign explicit = ctrl_i.set_en | ctrl_i.clr_en | ctrl_i.bst_en;

    always_comb begin
        sreg_d = sreg_q;
        if (ctrl_i.set_en) begin
            sreg_d = sreg_q | mask;
        end else if (ctrl_i.clr_en) begin
            sreg_d = sreg_q & ~mask;
        end else if (ctrl_i.bst_en) begin
            sreg_d[FL_T] = t_new_i;
        end else if (ext_we_i) begin
            sreg_d = ext_flags_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sreg_q <= '0;
        else     sreg_q <= sreg_d;
    end

    assign sreg_o = sreg_q;

    logic unused_explicit;
    assign unused_explicit = explicit;
endmodule

// File: rtl/sreg_bitxfer.sv
module sreg_bitxfer
    import sreg_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int BIDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bld_en_i,
    input  logic [BIDX_W-1:0] bit_idx_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              t_cur_i,
    output logic              t_new_o,
    output logic [DATA_W-1:0] data_o,
    output logic              we_o
);
    logic [DATA_W-1:0] merged;

    assign t_new_o = data_i[bit_idx_i];

    always_comb begin
        merged = data_i;
        merged[bit_idx_i] = t_cur_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
            we_o   <= 1'b0;
        end else begin
            we_o <= bld_en_i;
            if (bld_en_i) data_o <= merged;
        end
    end
endmodule

// File: rtl/sreg_branch.sv
module sreg_branch
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              br_en_i,
    input  logic              br_want_i,
    input  logic [FIDX_W-1:0] sel_i,
    input  logic [SREG_W-1:0] sreg_i,
    output logic              valid_o,
    output logic              taken_o,
    output logic [1:0]        cycles_o
);
    logic hit;
    assign hit = (sreg_i[sel_i] == br_want_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            taken_o  <= 1'b0;
            cycles_o <= 2'd0;
        end else begin
            valid_o  <= br_en_i;
            taken_o  <= br_en_i & hit;
            cycles_o <= !br_en_i ? 2'd0 : (hit ? 2'd2 : 2'd1);
        end
    end
endmodule

// File: rtl/sreg_bitman_unit.sv
module sreg_bitman_unit
    import sreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  op_i,
    input  logic [2:0]  flag_idx_i,
    input  logic [2:0]  bit_idx_i,
    input  logic [7:0]  reg_data_i,
    input  logic        ext_we_i,
    input  logic [7:0]  ext_flags_i,
    output logic [7:0]  sreg_o,
    output logic [7:0]  reg_data_o,
    output logic        reg_we_o,
    output logic        br_valid_o,
    output logic        br_taken_o,
    output logic [1:0]  br_cycles_o
);
    ctrl_t             ctrl;
    logic              t_new;
    logic [SREG_W-1:0] sreg;

    sreg_decode u_dec (
        .op_i       (op_i),
        .flag_idx_i (flag_idx_i),
        .ctrl_o     (ctrl)
    );

    sreg_file u_file (
        .clk         (clk),
        .rst         (rst),
        .ctrl_i      (ctrl),
        .t_new_i     (t_new),
        .ext_we_i    (ext_we_i),
        .ext_flags_i (ext_flags_i),
        .sreg_o      (sreg)
    );

    sreg_bitxfer #(.DATA_W(8)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .bld_en_i  (ctrl.bld_en),
        .bit_idx_i (bit_idx_i),
        .data_i    (reg_data_i),
        .t_cur_i   (sreg[FL_T]),
        .t_new_o   (t_new),
        .data_o    (reg_data_o),
        .we_o      (reg_we_o)
    );

    sreg_branch u_br (
        .clk       (clk),
        .rst       (rst),
        .br_en_i   (ctrl.br_en),
        .br_want_i (ctrl.br_want),
        .sel_i     (ctrl.sel),
        .sreg_i    (sreg),
        .valid_o   (br_valid_o),
        .taken_o   (br_taken_o),
        .cycles_o  (br_cycles_o)
    );

    assign sreg_o = sreg;
endmodule

// File: rtl/sreg_bitman_checker.sv
module sreg_bitman_checker
    import sreg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [4:0] op_i,
    input logic [2:0] flag_idx_i,
    input logic [2:0] bit_idx_i,
    input logic [7:0] reg_data_i,
    input logic       ext_we_i,
    input logic [7:0] ext_flags_i,
    input logic [7:0] sreg_o,
    input logic [7:0] reg_data_o,
    input logic       reg_we_o,
    input logic       br_valid_o,
    input logic       br_taken_o,
    input logic [1:0] br_cycles_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (sreg_o == 8'h00 && !reg_we_o && !br_valid_o));

    a_r2_indexed_set: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_FSET |=> sreg_o[$past(flag_idx_i)] == 1'b1);

    a_r3_indexed_clear: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_FCLR |=> sreg_o[$past(flag_idx_i)] == 1'b0);

    a_r4_short_form: assert property (@(posedge clk) disable iff (rst)
        op_i[4] |=> sreg_o[$past(op_i[2:0])] == $past(op_i[3]));

    a_r6_bit_store: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_BST |=> (sreg_o[6] == $past(reg_data_i[bit_idx_i])
                            && sreg_o[5:0] == $past(sreg_o[5:0])
                            && sreg_o[7] == $past(sreg_o[7])));

    a_r7_load_no_flag: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_BLD && !ext_we_i) |=> (reg_we_o && $stable(sreg_o)));

    a_r7_strobe_source: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |-> $past(op_i == OP_BLD));

    a_r8_branch_verdict: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_BRSET |=> (br_valid_o && br_taken_o == $past(sreg_o[flag_idx_i])));

    a_r9_branch_cost: assert property (@(posedge clk) disable iff (rst)
        br_valid_o |-> br_cycles_o == (br_taken_o ? 2'd2 : 2'd1));

    a_r10_external_word: assert property (@(posedge clk) disable iff (rst)
        (ext_we_i && op_i == OP_NOP) |=> sreg_o == $past(ext_flags_i));

    a_r11_idle_codes: assert property (@(posedge clk) disable iff (rst)
        (op_i >= 5'h07 && op_i <= 5'h0F && !ext_we_i) |=> ($stable(sreg_o) && !reg_we_o && !br_valid_o));
endmodule

bind sreg_bitman_unit sreg_bitman_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_i        (op_i),
    .flag_idx_i  (flag_idx_i),
    .bit_idx_i   (bit_idx_i),
    .reg_data_i  (reg_data_i),
    .ext_we_i    (ext_we_i),
    .ext_flags_i (ext_flags_i),
    .sreg_o      (sreg_o),
    .reg_data_o  (reg_data_o),
    .reg_we_o    (reg_we_o),
    .br_valid_o  (br_valid_o),
    .br_taken_o  (br_taken_o),
    .br_cycles_o (br_cycles_o)
);

// File: tb/tb_sreg_bitman_unit.sv
module tb_sreg_bitman_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_i = '0;
    logic [2:0] flag_idx_i = '0;
    logic [2:0] bit_idx_i = '0;
    logic [7:0] reg_data_i = '0;
    logic       ext_we_i = 1'b0;
    logic [7:0] ext_flags_i = '0;
    logic [7:0] sreg_o, reg_data_o;
    logic       reg_we_o, br_valid_o, br_taken_o;
    logic [1:0] br_cycles_o;

    always #2 clk = ~clk;

    sreg_bitman_unit dut (.*);

    typedef struct packed {
        logic [4:0] op;
        logic [2:0] fidx;
        logic [2:0] bidx;
        logic [7:0] data;
        logic       ew;
        logic [7:0] ef;
        logic [7:0] esreg;
        logic       ewe;
        logic [7:0] edata;
        logic       ebv;
        logic       ebt;
        logic [1:0] ecyc;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{5'h01, 3'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h01, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0},
        '{5'h01, 3'd7, 3'd0, 8'h00, 1'b0, 8'h00, 8'h81, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0},
        '{5'h02, 3'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h80, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0},
        '{5'h19, 3'd4, 3'd0, 8'h00, 1'b0, 8'h00, 8'h82, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0},
        '{5'h1E, 3'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'hC2, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0},
        '{5'h17, 3'd1, 3'd0, 8'h00, 1'b0, 8'h00, 8'h42, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0},
        '{5'h05, 3'd6, 3'd0, 8'h00, 1'b0, 8'h00, 8'h42, 1'b0, 8'h00, 1'b1, 1'b1, 2'd2},
        '{5'h05, 3'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h42, 1'b0, 8'h00, 1'b1, 1'b0, 2'd1},
        '{5'h06, 3'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h42, 1'b0, 8'h00, 1'b1, 1'b1, 2'd2},
        '{5'h04, 3'd0, 3'd3, 8'h00, 1'b0, 8'h00, 8'h42, 1'b1, 8'h08, 1'b0, 1'b0, 2'd0},
        '{5'h03, 3'd0, 3'd5, 8'hDF, 1'b0, 8'h00, 8'h02, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0},
        '{5'h04, 3'd0, 3'd7, 8'hFF, 1'b0, 8'h00, 8'h02, 1'b1, 8'h7F, 1'b0, 1'b0, 2'd0},
        '{5'h03, 3'd0, 3'd0, 8'h01, 1'b0, 8'h00, 8'h42, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0},
        '{5'h00, 3'd0, 3'd0, 8'h00, 1'b1, 8'h3C, 8'h3C, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0},
        '{5'h02, 3'd2, 3'd0, 8'h00, 1'b1, 8'hFF, 8'h38, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0},
        '{5'h04, 3'd0, 3'd0, 8'hAA, 1'b1, 8'h00, 8'h00, 1'b1, 8'hAA, 1'b0, 1'b0, 2'd0},
        '{5'h08, 3'd5, 3'd1, 8'hFF, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0},
        '{5'h1B, 3'd0, 3'd0, 8'h00, 1'b0, 8'h00, 8'h08, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0},
        '{5'h01, 3'd6, 3'd0, 8'h00, 1'b1, 8'h00, 8'h48, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0}
    };

    localparam string TAG [NV] = '{
        "R2", "R2", "R3", "R4 R5", "R4 R5", "R4 R5", "R8 R9", "R8 R9", "R8 R9",
        "R7", "R6", "R7", "R6", "R10", "R10", "R7 R10", "R11", "R4 R5", "R10"
    };

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_i        = v.op;
        flag_idx_i  = v.fidx;
        bit_idx_i   = v.bidx;
        reg_data_i  = v.data;
        ext_we_i    = v.ew;
        ext_flags_i = v.ef;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "sreg", int'(sreg_o), 0);
        check("R1", "we", int'(reg_we_o), 0);
        check("R1", "br_valid", int'(br_valid_o), 0);
        check("R1", "br_cycles", int'(br_cycles_o), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check(TAG[i], "sreg", int'(sreg_o), int'(VEC[i].esreg));
            check(TAG[i], "reg_we", int'(reg_we_o), int'(VEC[i].ewe));
            if (VEC[i].ewe) check(TAG[i], "reg_data", int'(reg_data_o), int'(VEC[i].edata));
            check(TAG[i], "br_valid", int'(br_valid_o), int'(VEC[i].ebv));
            check(TAG[i], "br_taken", int'(br_taken_o), int'(VEC[i].ebt));
            check(TAG[i], "br_cycles", int'(br_cycles_o), int'(VEC[i].ecyc));
        end

        // R7: strobe lasts a single cycle
        drive('{5'h04, 3'd0, 3'd2, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0});
        @(negedge clk);
        check("R7", "bld T=1 data", int'(reg_data_o), 8'h04);
        op_i = 5'h00;
        @(negedge clk);
        check("R7", "strobe drop", int'(reg_we_o), 0);
        check("R9", "cycles idle", int'(br_cycles_o), 0);

        // R1: reset beats a pending set
        op_i = 5'h01; flag_idx_i = 3'd1; rst = 1'b1;
        @(negedge clk);
        check("R1", "reset over set", int'(sreg_o), 0);
        rst = 1'b0; op_i = 5'h00;
        @(negedge clk);
        check("R1", "after reset", int'(sreg_o), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule